// File: doc/BRIEF.md
# Double-Frequency Read Clock/Data Separator

This block takes the pulse train recovered from flux reversals on a double-frequency (FM) recorded track and splits it into clock strobes and data strobes. Every bit cell begins with a clock pulse, and a data pulse appears near the middle of the cell only when the bit is a one. After each clock pulse the block opens a timed acceptance window. A pulse that lands inside the window is a data one. If the window runs out with no pulse, the cell is a zero. When each cell ends, the block reports the recovered bit together with a one-cycle valid strobe.

All timing is counted in cycles of a fast system clock, which oversamples the pulse train. The window length follows a running average of the measured spacing between clock pulses, so the window keeps the same fraction of the cell when the medium speed drifts. Recorded ones can arrive late because of peak shift. For that reason, whenever the previous cell held a zero, the next window is stretched by a fixed number of cycles. The pulse input is asynchronous and several cycles wide. It is synchronised and reduced to a single-cycle event before it is classified.

Top module: `fm_read_separator`

## Requirements
- R1: Each rising edge of `pulse_i` yields exactly one event. The resulting strobe (`rd_clk_o` or `rd_data_o`) is high for one cycle, on the third clock edge after the first edge that samples `pulse_i` high.
- R2: A pulse that arrives while no window is open raises `rd_clk_o`, opens a window and starts a new cell.
- R3: A pulse that arrives d cycles after the clock pulse of an open cell, with d smaller than that cell's window limit, raises `rd_data_o`, and the cell is reported as a one.
- R4: A pulse that arrives at d greater than or equal to the window limit is a clock pulse. The previous cell is reported as a zero, at the same edge as the new `rd_clk_o` strobe or earlier.
- R5: When no data pulse arrives, `bit_vld_o` rises with `bit_val_o` = 0 exactly limit cycles after the cell's `rd_clk_o` strobe.
- R6: A data pulse that is still high when the limit is reached holds the window open. In that case `bit_vld_o` (with `bit_val_o` = 1) rises on the third edge after the first edge that samples `pulse_i` low.
- R7: The window limit is (avg >> 1) + MARGIN, plus ZERO_EXT cycles when the previous cell was a zero. The first cell after reset is treated as if it followed a one.
- R8: The average starts at PER_NOM after reset. At each clock pulse except the first one after reset, it becomes avg + floor((meas − avg) / 2^AVG_SHIFT), clamped to [PER_MIN, PER_MAX]. Here meas is the number of cycles between the two latest clock pulses. Each clock pulse uses the average as it stood before that pulse's own update.
- R9: During and directly after reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (oversampling) |
| rst_i | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Asynchronous pulse train, one pulse per flux reversal |
| rd_clk_o | output | 1 | One-cycle strobe for each clock pulse |
| rd_data_o | output | 1 | One-cycle strobe for each data-one pulse |
| bit_vld_o | output | 1 | One-cycle strobe when a cell ends |
| bit_val_o | output | 1 | Recovered bit, valid with bit_vld_o |

## Verification
A faulty running average or extension flag does not stay hidden. It moves the moment at which a zero cell closes, so the gap between `rd_clk_o` and `bit_vld_o` is off within the first cell that uses the bad value. It also shifts the boundary at which a late pulse stops counting as data and becomes a clock. The bench therefore sweeps the offset of the pulse across that boundary, both after a one and after a zero, and times the closes of zero cells across a sequence of cell periods. A stuck hold or a mis-classified event shows up at once in the counts of clock and data strobes.

// File: rtl/fm_sep_pkg.sv
package fm_sep_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_CLOCK = 2'd1,
        EV_DATA  = 2'd2
    } ev_kind_e;

endpackage

// File: rtl/fm_pulse_sync.sv
module fm_pulse_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pulse_i,
    output logic ev_o,
    output logic lvl_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC_N-2:0], pulse_i};
        st_d.prev = st_q.sh[SYNC_N-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign lvl_o = st_q.sh[SYNC_N-1];
    assign ev_o  = st_q.sh[SYNC_N-1] & ~st_q.prev;

    AST_EV_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_o |=> !ev_o); // R1

endmodule

// File: rtl/fm_period_track.sv
module fm_period_track #(
    parameter int CNT_W     = 8,
    parameter int PER_NOM   = 50,
    parameter int PER_MIN   = 30,
    parameter int PER_MAX   = 80,
    parameter int AVG_SHIFT = 3,
    parameter int MARGIN    = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clk_evt_i,
    output logic [CNT_W-1:0] win_len_o
);
    localparam int W2 = CNT_W + 2;
    localparam logic signed [W2-1:0] MIN_S = W2'(PER_MIN);
    localparam logic signed [W2-1:0] MAX_S = W2'(PER_MAX);
    localparam logic [CNT_W-1:0]     NOM_C = CNT_W'(PER_NOM);
    localparam logic [CNT_W-1:0]     MRG_C = CNT_W'(MARGIN);

    typedef struct packed {
        logic [CNT_W-1:0] avg;
        logic [CNT_W-1:0] per_cnt;
        logic             have_prev;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic signed [W2-1:0] diff, step, nxt;

    always_comb begin
        st_d = st_q;
        diff = $signed({2'b00, st_q.per_cnt}) - $signed({2'b00, st_q.avg});
        step = diff >>> AVG_SHIFT;
        nxt  = $signed({2'b00, st_q.avg}) + step;

        if (st_q.per_cnt != '1) st_d.per_cnt = st_q.per_cnt + 1'b1;

        if (clk_evt_i) begin
            if (st_q.have_prev) begin
                if (nxt < MIN_S)      st_d.avg = CNT_W'(PER_MIN);
                else if (nxt > MAX_S) st_d.avg = CNT_W'(PER_MAX);
                else                  st_d.avg = nxt[CNT_W-1:0];
            end
            st_d.per_cnt   = CNT_W'(1);
            st_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.avg       <= NOM_C;
            st_q.per_cnt   <= '0;
            st_q.have_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_len_o = (st_q.avg >> 1) + MRG_C;

    AST_AVG_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.avg >= CNT_W'(PER_MIN)) && (st_q.avg <= CNT_W'(PER_MAX))); // R8
    AST_AVG_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_evt_i |=> $stable(st_q.avg)); // R8

endmodule

// File: rtl/fm_window_ctl.sv
module fm_window_ctl
    import fm_sep_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int ZERO_EXT = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ev_i,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] win_len_i,
    output logic             clk_evt_o,
    output logic             rd_clk_o,
    output logic             rd_data_o,
    output logic             bit_vld_o,
    output logic             bit_val_o
);
    localparam logic [CNT_W-1:0] EXT_C = CNT_W'(ZERO_EXT);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] age;
        logic [CNT_W-1:0] limit;
        logic             hold;
        logic             got_one;
        logic             one_flag;
        logic             rd_clk;
        logic             rd_data;
        logic             bit_vld;
        logic             bit_val;
    } win_st_t;

    win_st_t  st_d, st_q;
    ev_kind_e kind;
    logic     expired;

    always_comb begin
        st_d         = st_q;
        st_d.rd_clk  = 1'b0;
        st_d.rd_data = 1'b0;
        st_d.bit_vld = 1'b0;
        st_d.hold    = st_q.hold & lvl_i;
        expired      = st_q.open && (st_q.age >= st_q.limit);

        kind = EV_NONE;
        if (ev_i) kind = (st_q.open && !expired) ? EV_DATA : EV_CLOCK;

        if (st_q.open && (st_q.age != '1)) st_d.age = st_q.age + 1'b1;

        case (kind)
            EV_CLOCK: begin
                if (st_q.open) begin
                    st_d.bit_vld = 1'b1;
                    st_d.bit_val = st_q.got_one;
                end
                st_d.open     = 1'b1;
                st_d.age      = CNT_W'(1);
                st_d.limit    = win_len_i + (st_q.one_flag ? '0 : EXT_C);
                st_d.one_flag = 1'b0;
                st_d.got_one  = 1'b0;
                st_d.hold     = 1'b0;
                st_d.rd_clk   = 1'b1;
            end
            EV_DATA: begin
                st_d.got_one  = 1'b1;
                st_d.hold     = 1'b1;
                st_d.one_flag = 1'b1;
                st_d.rd_data  = 1'b1;
            end
            default: begin
                if (expired && !(st_q.hold && lvl_i)) begin
                    st_d.open    = 1'b0;
                    st_d.bit_vld = 1'b1;
                    st_d.bit_val = st_q.got_one;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q          <= '0;
            st_q.one_flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_evt_o = (kind == EV_CLOCK);
    assign rd_clk_o  = st_q.rd_clk;
    assign rd_data_o = st_q.rd_data;
    assign bit_vld_o = st_q.bit_vld;
    assign bit_val_o = st_q.bit_val;

    AST_CLK_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.rd_clk |-> (st_q.open && st_q.age == CNT_W'(1))); // R2
    AST_DATA_IN_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.rd_data |-> (st_q.open && st_q.got_one)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({st_q.rd_clk, st_q.rd_data})); // R4
    AST_CLOSE_AT_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(st_q.open) |-> ($past(st_q.age) >= $past(st_q.limit))); // R5
    AST_HOLD_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.open && st_q.hold && lvl_i && !ev_i) |=> st_q.open); // R6

endmodule

// File: rtl/fm_read_separator.sv
module fm_read_separator #(
    parameter int SYNC_N    = 2,
    parameter int CNT_W     = 8,
    parameter int PER_NOM   = 50,
    parameter int PER_MIN   = 30,
    parameter int PER_MAX   = 80,
    parameter int AVG_SHIFT = 3,
    parameter int MARGIN    = 4,
    parameter int ZERO_EXT  = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pulse_i,
    output logic rd_clk_o,
    output logic rd_data_o,
    output logic bit_vld_o,
    output logic bit_val_o
);
    logic             ev, lvl, clk_evt;
    logic [CNT_W-1:0] win_len;

    fm_pulse_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pulse_i(pulse_i),
        .ev_o   (ev),
        .lvl_o  (lvl)
    );

    fm_period_track #(
        .CNT_W(CNT_W), .PER_NOM(PER_NOM), .PER_MIN(PER_MIN),
        .PER_MAX(PER_MAX), .AVG_SHIFT(AVG_SHIFT), .MARGIN(MARGIN)
    ) u_track (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clk_evt_i(clk_evt),
        .win_len_o(win_len)
    );

    fm_window_ctl #(.CNT_W(CNT_W), .ZERO_EXT(ZERO_EXT)) u_win (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ev_i     (ev),
        .lvl_i    (lvl),
        .win_len_i(win_len),
        .clk_evt_o(clk_evt),
        .rd_clk_o (rd_clk_o),
        .rd_data_o(rd_data_o),
        .bit_vld_o(bit_vld_o),
        .bit_val_o(bit_val_o)
    );

endmodule

// File: tb/fm_read_separator_tb_top.sv
`timescale 1ns/1ps
module fm_read_separator_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse = 1'b0;
    logic rd_clk, rd_data, bit_vld, bit_val;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_clk, n_data, n_vld;
    int clk_at [64];
    int vld_at [64];
    int vld_bit [64];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fm_read_separator dut_i (
        .clk_i(clk), .rst_i(rst), .pulse_i(pulse),
        .rd_clk_o(rd_clk), .rd_data_o(rd_data),
        .bit_vld_o(bit_vld), .bit_val_o(bit_val)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_clk) begin
                if (n_clk < 64) clk_at[n_clk] = cyc;
                n_clk++;
            end
            if (rd_data) n_data++;
            if (bit_vld) begin
                if (n_vld < 64) begin
                    vld_at[n_vld]  = cyc;
                    vld_bit[n_vld] = int'(bit_val);
                end
                n_vld++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic gap(input int n);
        pulse = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pls(input int w, output int start);
        start = cyc;
        pulse = 1'b1;
        repeat (w) @(negedge clk);
        pulse = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_clk = 0; n_data = 0; n_vld = 0;
    endtask

    // Zero-cell timing over a run of clock-only pulses at period p (R7, R8)
    task automatic track_run(input int p, input int n);
        int avg = 50;
        int flag = 1;
        int hp = 0;
        int lim [64];
        int s;
        do_reset();
        for (int k = 0; k < n; k++) begin
            lim[k] = (avg >> 1) + 4 + (flag != 0 ? 0 : 8);
            flag = 0;
            if (hp != 0) begin
                avg = avg + ((p - avg) >>> 3);
                if (avg < 30) avg = 30;
                if (avg > 80) avg = 80;
            end
            hp = 1;
            pls(15, s);
            gap(p - 15);
        end
        gap(150);
        check("R8", n_vld, n, "cell count");
        for (int k = 0; k < n; k++) begin
            check("R7", vld_at[k] - clk_at[k], lim[k], $sformatf("window limit p=%0d cell %0d", p, k));
            check("R5", vld_bit[k], 0, "zero cell value");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int s, sd;
        // R9: reset state
        repeat (2) @(negedge clk);
        check("R9", int'({rd_clk, rd_data, bit_vld, bit_val}), 0, "outputs during reset");
        do_reset();
        check("R9", int'({rd_clk, rd_data, bit_vld, bit_val}), 0, "outputs after reset");

        // R1, R5: single clock pulse, first cell uses no extension
        pls(15, s);
        gap(200);
        check("R1", clk_at[0], s + 3, "rd_clk latency");
        check("R1", n_clk, 1, "one strobe per pulse");
        check("R5", vld_at[0], s + 3 + 29, "zero cell close");
        check("R5", vld_bit[0], 0, "zero cell value");

        // R6: data pulse held past the limit
        do_reset();
        pls(5, s);
        gap(22);
        pls(30, sd);
        gap(100);
        check("R6", sd - s, 27, "data offset setup");
        check("R6", vld_at[0], sd + 30 + 3, "held window close");
        check("R6", vld_bit[0], 1, "held cell value");
        check("R3", n_data, 1, "data strobe count");

        // R3, R4, R7: sweep of the test pulse offset after a one and after a zero
        for (int po = 0; po < 2; po++) begin
            for (int d = 22; d <= 42; d++) begin
                int lim;
                int one;
                do_reset();
                pls(15, s);
                if (po == 1) begin
                    gap(5);
                    pls(15, s);
                    gap(15);
                end else begin
                    gap(35);
                end
                pls(15, s);
                gap(d - 15);
                pls(15, s);
                gap(120);
                lim = 29 + (po == 1 ? 0 : 8);
                one = (d < lim) ? 1 : 0;
                check(one != 0 ? "R3" : "R4", n_clk, 3 - one, $sformatf("clock strobes po=%0d d=%0d", po, d));
                check("R3", n_data, po + one, $sformatf("data strobes po=%0d d=%0d", po, d));
                check("R4", n_vld, 3 - one, $sformatf("cells po=%0d d=%0d", po, d));
                check("R7", vld_bit[1], one, $sformatf("tested cell bit po=%0d d=%0d", po, d));
                check("R2", vld_bit[0], po, $sformatf("first cell bit po=%0d d=%0d", po, d));
            end
        end

        // R8: tracking toward a slower period and clamping at the maximum
        track_run(60, 12);
        track_run(120, 8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule